// File: doc/BRIEF.md
# Privileged Flags Register Controller

This block keeps the 32-bit processor flags word and enforces the rules that govern how software and instruction flow may change it. Software updates the word through a write port that carries a data word and a per-bit write mask. The current privilege level decides whether the interrupt-enable bit and the two-bit I/O privilege field actually take the written value. A masked-off or refused bit keeps its old value.

The block also handles the control flags that change without an explicit write. When the trap flag is set, each retiring instruction raises a held single-step trap request. Taking the trap clears both the request and the trap flag. The resume flag hides debug-fault candidates while it is set. It is cleared when an ordinary instruction retires, and it is kept when the retiring instruction is an interrupt return, a flag pop or a task switch. The direction flag is given out as a string index step of +1 or −1, and the privilege comparison is given out as an I/O permission signal.

Top module: `flagctl_top`

## Requirements
- R1: After reset the flags word reads 0x00000002, the trap request is 0, and the string step is +1.
- R2: Bit 1 always reads 1. Bits 3, 5, 15 and 17 to 31 always read 0, and writes to them have no effect.
- R3: On a write, each bit among 0, 2, 4, 6, 7 (arithmetic status), 8 (trap), 10 (direction), 11 (overflow) and 14 (nested task) takes the write data where its mask bit is 1 and keeps its value where its mask bit is 0. The result is visible from the cycle after the write.
- R4: Bit 9 (interrupt enable) takes written data only when the privilege input is numerically less than or equal to the current I/O privilege field (bits 13:12). Otherwise it keeps its old value, while the other masked bits of the same write still apply.
- R5: The I/O privilege field (bits 13:12) takes written data only when the privilege input is 0. At any other level it keeps its value.
- R6: `io_ok` is 1 exactly when the privilege input is less than or equal to the current I/O privilege field.
- R7: A retire pulse while the trap flag is set makes `step_req` 1 from the next cycle. The request holds until `step_taken`. A `step_taken` pulse clears both `step_req` and the trap flag in the next cycle.
- R8: An instruction whose retire coincides with the write that sets the trap flag does not raise a trap request. Only the following retire does.
- R9: With `dbg_cand` high, `dbg_hide` equals the resume flag (bit 16) and `dbg_fault` equals its inverse. Both are 0 when `dbg_cand` is low.
- R10: A retire with class 0 (plain) clears the resume flag, and this clear wins over a write in the same cycle. Retire classes 1 (interrupt return), 2 (flag pop) and 3 (task switch) leave it unchanged, so a write in that cycle applies.
- R11: `str_step` is 2'b01 (+1) while the direction flag (bit 10) is 0 and 2'b11 (−1) while it is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write enable |
| cpl | input | 2 | Current privilege level |
| retire | input | 1 | Instruction retire pulse |
| retire_class | input | 2 | Class of the retiring instruction (0 plain, 1 interrupt return, 2 flag pop, 3 task switch) |
| step_taken | input | 1 | Single-step trap taken |
| dbg_cand | input | 1 | Debug-fault candidate at the instruction boundary |
| flags | output | 32 | Flags word |
| step_req | output | 1 | Pending single-step trap request |
| dbg_hide | output | 1 | Debug fault suppressed |
| dbg_fault | output | 1 | Debug fault passed on |
| str_step | output | 2 | Signed string index step |
| io_ok | output | 1 | I/O permitted at current privilege |

## Verification
The assertions assume that `retire` and `step_taken` are single-cycle pulses that are never both high in the same cycle. They also assume that `retire_class` is meaningful only while `retire` is high. The directed stimulus raises each event pulse for exactly one cycle and never overlaps a trap acceptance with a retire. Privilege changes are applied between writes, and each assertion therefore sees the same privilege value that the write logic used.

// File: rtl/flagctl_pkg.sv
package flagctl_pkg;
  localparam int FLAG_W   = 32;
  localparam int CPL_W    = 2;

  localparam int B_CF     = 0;
  localparam int B_ONE    = 1;
  localparam int B_PF     = 2;
  localparam int B_AF     = 4;
  localparam int B_ZF     = 6;
  localparam int B_SF     = 7;
  localparam int B_TRAP   = 8;
  localparam int B_IEN    = 9;
  localparam int B_DIR    = 10;
  localparam int B_OVF    = 11;
  localparam int B_PL_LO  = 12;
  localparam int B_PL_HI  = 13;
  localparam int B_NEST   = 14;
  localparam int B_RESUME = 16;

  typedef enum logic [1:0] {
    RC_PLAIN       = 2'd0,
    RC_INT_RETURN  = 2'd1,
    RC_FLAG_POP    = 2'd2,
    RC_TASK_SWITCH = 2'd3
  } retire_class_e;

  function automatic logic [FLAG_W-1:0] free_bits();
    logic [FLAG_W-1:0] m;
    m = '0;
    m[B_CF]   = 1'b1;
    m[B_PF]   = 1'b1;
    m[B_AF]   = 1'b1;
    m[B_ZF]   = 1'b1;
    m[B_SF]   = 1'b1;
    m[B_TRAP] = 1'b1;
    m[B_DIR]  = 1'b1;
    m[B_OVF]  = 1'b1;
    m[B_NEST] = 1'b1;
    m[B_RESUME] = 1'b1;
    return m;
  endfunction

  function automatic logic [FLAG_W-1:0] fixed_ones();
    logic [FLAG_W-1:0] m;
    m = '0;
    m[B_ONE] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/flagctl_wgate.sv
module flagctl_wgate
  import flagctl_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int PW = CPL_W
) (
  input  logic          wr_en,
  input  logic [FW-1:0] wr_mask,
  input  logic [PW-1:0] cpl,
  input  logic [PW-1:0] iopl_q,
  output logic [FW-1:0] eff_mask,
  output logic          io_ok
);
  localparam logic [FW-1:0] FREE = FW'(free_bits());

  logic ien_ok;
  logic pl_ok;
  logic [FW-1:0] priv_bits;

  always_comb begin
    io_ok  = (cpl <= iopl_q);
    ien_ok = io_ok;
    pl_ok  = (cpl == '0);
    priv_bits = '0;
    priv_bits[B_IEN]   = ien_ok;
    priv_bits[B_PL_LO] = pl_ok;
    priv_bits[B_PL_HI] = pl_ok;
    eff_mask = wr_en ? (wr_mask & (FREE | priv_bits)) : '0;
  end
endmodule

// File: rtl/flagctl_step.sv
module flagctl_step (
  input  logic clk,
  input  logic rst_n,
  input  logic trap_q,
  input  logic retire,
  input  logic step_taken,
  output logic step_req,
  output logic trap_clr
);
  logic req_q, req_d;

  always_comb begin
    req_d = req_q;
    if (step_taken)
      req_d = 1'b0;
    else if (retire && trap_q)
      req_d = 1'b1;
    trap_clr = step_taken;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  assign step_req = req_q;

  p_step_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && trap_q && !step_taken) |=> step_req);
  p_step_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (step_req && !step_taken) |=> step_req);
  p_step_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_taken |=> !step_req);
endmodule

// File: rtl/flagctl_resume.sv
module flagctl_resume
  import flagctl_pkg::*;
(
  input  logic       resume_q,
  input  logic       retire,
  input  logic [1:0] retire_class,
  input  logic       dbg_cand,
  output logic       resume_clr,
  output logic       dbg_hide,
  output logic       dbg_fault
);
  always_comb begin
    resume_clr = retire && (retire_class_e'(retire_class) == RC_PLAIN);
    dbg_hide   = dbg_cand && resume_q;
    dbg_fault  = dbg_cand && !resume_q;
  end
endmodule

// File: rtl/flagctl_top.sv
module flagctl_top
  import flagctl_pkg::*;
#(
  parameter int FW = FLAG_W,
  parameter int PW = CPL_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [FW-1:0] wr_data,
  input  logic [FW-1:0] wr_mask,
  input  logic [PW-1:0] cpl,
  input  logic          retire,
  input  logic [1:0]    retire_class,
  input  logic          step_taken,
  input  logic          dbg_cand,
  output logic [FW-1:0] flags,
  output logic          step_req,
  output logic          dbg_hide,
  output logic          dbg_fault,
  output logic [1:0]    str_step,
  output logic          io_ok
);
  localparam logic [FW-1:0] ONES  = FW'(fixed_ones());
  localparam logic [FW-1:0] KEEP  = FW'(free_bits()) | ONES |
                                    (FW'(1) << B_IEN) | (FW'(3) << B_PL_LO);
  localparam logic [FW-1:0] RESET_VAL = ONES;

  logic [FW-1:0] flags_q, flags_d;
  logic [FW-1:0] eff_mask;
  logic          flags_en;
  logic          trap_clr;
  logic          resume_clr;

  flagctl_wgate #(.FW(FW), .PW(PW)) u_wgate (
    .wr_en    (wr_en),
    .wr_mask  (wr_mask),
    .cpl      (cpl),
    .iopl_q   (flags_q[B_PL_HI:B_PL_LO]),
    .eff_mask (eff_mask),
    .io_ok    (io_ok)
  );

  flagctl_step u_step (
    .clk        (clk),
    .rst_n      (rst_n),
    .trap_q     (flags_q[B_TRAP]),
    .retire     (retire),
    .step_taken (step_taken),
    .step_req   (step_req),
    .trap_clr   (trap_clr)
  );

  flagctl_resume u_resume (
    .resume_q     (flags_q[B_RESUME]),
    .retire       (retire),
    .retire_class (retire_class),
    .dbg_cand     (dbg_cand),
    .resume_clr   (resume_clr),
    .dbg_hide     (dbg_hide),
    .dbg_fault    (dbg_fault)
  );

  always_comb begin
    flags_en = (eff_mask != '0) || trap_clr || resume_clr;
    flags_d  = (flags_q & ~eff_mask) | (wr_data & eff_mask);
    if (trap_clr)   flags_d[B_TRAP]   = 1'b0;
    if (resume_clr) flags_d[B_RESUME] = 1'b0;
    flags_d = (flags_d & KEEP) | ONES;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= RESET_VAL;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags    = flags_q;
  assign str_step = flags_q[B_DIR] ? 2'b11 : 2'b01;

  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flags[B_ONE] && ((flags & ~KEEP) == '0));
  p_ien_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl > flags[B_PL_HI:B_PL_LO]) |=> $stable(flags[B_IEN]));
  p_iopl_guard_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl != '0) |=> $stable(flags[B_PL_HI:B_PL_LO]));
  p_resume_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && retire_class == 2'd0) |=> !flags[B_RESUME]);
  p_resume_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && retire_class != 2'd0 && !wr_en) |=> $stable(flags[B_RESUME]));
  p_dir_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[B_DIR]) |-> (str_step == 2'b11));
endmodule

// File: tb/flagctl_top_tb.sv
module flagctl_top_tb;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] wr_mask;
  logic [1:0]  cpl;
  logic        retire;
  logic [1:0]  retire_class;
  logic        step_taken;
  logic        dbg_cand;
  logic [31:0] flags;
  logic        step_req;
  logic        dbg_hide;
  logic        dbg_fault;
  logic [1:0]  str_step;
  logic        io_ok;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flagctl_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_mask(wr_mask), .cpl(cpl), .retire(retire),
    .retire_class(retire_class), .step_taken(step_taken),
    .dbg_cand(dbg_cand), .flags(flags), .step_req(step_req),
    .dbg_hide(dbg_hide), .dbg_fault(dbg_fault), .str_step(str_step),
    .io_ok(io_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; returns at the following falling edge.
  task automatic cyc(input logic we, input logic [31:0] d, input logic [31:0] m,
                     input logic ret, input logic [1:0] rc, input logic st);
    @(negedge clk);
    wr_en = we; wr_data = d; wr_mask = m;
    retire = ret; retire_class = rc; step_taken = st;
    @(negedge clk);
    wr_en = 1'b0; retire = 1'b0; step_taken = 1'b0;
  endtask

  task automatic wr(input logic [31:0] d, input logic [31:0] m);
    cyc(1'b1, d, m, 1'b0, 2'd0, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 flags", flags, 32'h0000_0002);
    chk("R1 step_req", {31'd0, step_req}, 32'd0);
    chk("R1 str_step", {30'd0, str_step}, 32'd1);
  endtask

  task automatic t_fixed;
    cpl = 2'd0;
    wr(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    chk("R2 all-ones write", flags, 32'h0001_7FD7);
    wr(32'h0000_0000, 32'hFFFF_FFFF);
    chk("R2 all-zero write", flags, 32'h0000_0002);
    wr(32'hFFFF_FFFF, 32'hFFFE_8028);
    chk("R2 reserved ignored", flags, 32'h0000_0002);
  endtask

  task automatic t_masked;
    wr(32'h0000_FFFF, 32'h0000_00C1);
    chk("R3 masked set", flags, 32'h0000_00C3);
    wr(32'h0000_0000, 32'h0000_0400);
    chk("R3 masked clear no change", flags, 32'h0000_00C3);
    wr(32'h0000_0400, 32'h0000_0400);
    chk("R3 dir set", flags, 32'h0000_04C3);
    chk("R11 step minus", {30'd0, str_step}, 32'd3);
    wr(32'h0000_4000, 32'h0000_4400);
    chk("R3 nest set dir clear", flags, 32'h0000_40C3);
    chk("R11 step plus", {30'd0, str_step}, 32'd1);
    wr(32'h0, 32'hFFFF_FFFF);
  endtask

  task automatic t_priv;
    cpl = 2'd0;
    wr(32'h0000_2000, 32'h0000_3000);
    chk("R5 iopl at cpl0", flags, 32'h0000_2002);
    cpl = 2'd3;
    wr(32'h0000_0000, 32'h0000_3000);
    chk("R5 iopl kept at cpl3", flags, 32'h0000_2002);
    chk("R6 io_ok cpl3>iopl2", {31'd0, io_ok}, 32'd0);
    wr(32'h0000_0201, 32'h0000_0201);
    chk("R4 ien refused, carry taken", flags, 32'h0000_2003);
    cpl = 2'd2;
    #1;
    chk("R6 io_ok cpl2=iopl2", {31'd0, io_ok}, 32'd1);
    wr(32'h0000_0200, 32'h0000_0200);
    chk("R4 ien taken at cpl2", flags, 32'h0000_2203);
    cpl = 2'd3;
    wr(32'h0000_0000, 32'h0000_0200);
    chk("R4 ien clear refused", flags, 32'h0000_2203);
    cpl = 2'd1;
    #1;
    chk("R6 io_ok cpl1", {31'd0, io_ok}, 32'd1);
    cpl = 2'd0;
    wr(32'h0, 32'hFFFF_FFFF);
    chk("R5 restore", flags, 32'h0000_0002);
  endtask

  task automatic t_step;
    cyc(1'b1, 32'h0000_0100, 32'h0000_0100, 1'b1, 2'd2, 1'b0);
    chk("R8 trap flag set", flags, 32'h0000_0102);
    chk("R8 no request on setting retire", {31'd0, step_req}, 32'd0);
    cyc(1'b0, 32'h0, 32'h0, 1'b1, 2'd0, 1'b0);
    chk("R7 request raised", {31'd0, step_req}, 32'd1);
    cyc(1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 1'b0);
    chk("R7 request held", {31'd0, step_req}, 32'd1);
    cyc(1'b0, 32'h0, 32'h0, 1'b0, 2'd0, 1'b1);
    chk("R7 request cleared", {31'd0, step_req}, 32'd0);
    chk("R7 trap flag cleared", flags, 32'h0000_0002);
    cyc(1'b0, 32'h0, 32'h0, 1'b1, 2'd0, 1'b0);
    chk("R7 no request without trap", {31'd0, step_req}, 32'd0);
  endtask

  task automatic t_resume;
    wr(32'h0001_0000, 32'h0001_0000);
    chk("R10 resume set", flags, 32'h0001_0002);
    dbg_cand = 1'b1;
    #1;
    chk("R9 hidden", {30'd0, dbg_hide, dbg_fault}, 32'd2);
    for (int c = 1; c < 4; c++) begin
      cyc(1'b0, 32'h0, 32'h0, 1'b1, 2'(c), 1'b0);
      chk("R10 kept by excluded class", flags, 32'h0001_0002);
    end
    cyc(1'b0, 32'h0, 32'h0, 1'b1, 2'd0, 1'b0);
    chk("R10 cleared by plain retire", flags, 32'h0000_0002);
    chk("R9 passed on", {30'd0, dbg_hide, dbg_fault}, 32'd1);
    dbg_cand = 1'b0;
    #1;
    chk("R9 idle", {30'd0, dbg_hide, dbg_fault}, 32'd0);
    cyc(1'b1, 32'h0001_0000, 32'h0001_0000, 1'b1, 2'd0, 1'b0);
    chk("R10 clear beats write", flags, 32'h0000_0002);
    cyc(1'b1, 32'h0001_0000, 32'h0001_0000, 1'b1, 2'd2, 1'b0);
    chk("R10 write with flag pop", flags, 32'h0001_0002);
    wr(32'h0, 32'hFFFF_FFFF);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; wr_mask = '0; cpl = 2'd0;
    retire = 1'b0; retire_class = 2'd0; step_taken = 1'b0; dbg_cand = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fixed();
    t_masked();
    t_priv();
    t_step();
    t_resume();
    finish_run();
  end
endmodule